// File: doc/BRIEF.md
# Banked SRAM Wishbone Slave

This block is a classic-cycle Wishbone slave that sits in front of several asynchronous SRAM banks of equal width. The banks sit side by side to make up the bus word: bank k owns data bits `[k*BANK_DW +: BANK_DW]` and select bit k. Every bank sees the same address. A bank's chip enable and write enable are raised only while the bus cycle is qualified by both `wb_cyc` and `wb_stb`. The select lines decide which banks take part. The bus write enable decides which of those banks are written.

Acknowledge timing is set at run time by `wait_cfg`. An internal counter starts when a strobe is first qualified and counts up to the programmed value. Acknowledge is returned in that cycle and is given once per access. If the master holds the strobe after acknowledge, no second acknowledge is given until the strobe or cycle line drops. There is no stall output. Bursts and error responses are not supported. A bank count of one gives a plain pass-through with a single select bit. `wait_cfg` must stay constant while an access is in progress.

Top module: `wb_sram_banks`

## Requirements
- R1: Bank k write data is `wb_dat_w[k*BANK_DW +: BANK_DW]`. `wb_dat_r` is all banks' read data joined together, with bank k in the same bit slice. Both paths are combinational.
- R2: `mem_addr` equals `wb_adr` in every cycle and is shared by all banks.
- R3: When `wb_cyc` or `wb_stb` is low, every bit of `mem_ce` and `mem_we` is 0. This includes the case where `wb_we` is high without a strobe.
- R4: While `wb_cyc` and `wb_stb` are both high, `mem_ce[k]` equals `wb_sel[k]`.
- R5: While `wb_cyc` and `wb_stb` are both high, `mem_we[k]` equals `wb_sel[k] & wb_we`. With select 4'b1100 on a write, only banks 2 and 3 are written.
- R6: With `wait_cfg` = 0, `wb_ack` is high in the first cycle of a qualified strobe.
- R7: With `wait_cfg` = W > 0, `wb_ack` is low in the first W cycles of a qualified strobe and high in cycle W (counting from 0).
- R8: Each access is acknowledged exactly once. While the strobe stays high after its acknowledge, `wb_ack` stays low. A new access, after the strobe has dropped and risen again, is timed afresh.
- R9: `wb_ack` is high only while `wb_cyc` and `wb_stb` are both high. Dropping `wb_cyc` before acknowledge abandons the count, and the next access starts again from cycle 0.
- R10: While `rst` is high, `wb_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | BANK_AW | Word address |
| wb_sel | input | BANKS | Byte-lane select, one bit per bank |
| wb_dat_w | input | BANKS*BANK_DW | Write data |
| wb_dat_r | output | BANKS*BANK_DW | Read data |
| wb_ack | output | 1 | Acknowledge |
| wait_cfg | input | WAIT_W | Wait cycles before acknowledge |
| mem_addr | output | BANK_AW | Shared bank address |
| mem_wdata | output | BANKS*BANK_DW | Bank write data, bank k in slice k |
| mem_rdata | input | BANKS*BANK_DW | Bank read data, bank k in slice k |
| mem_ce | output | BANKS | Per-bank chip enable |
| mem_we | output | BANKS | Per-bank write enable |

## Verification
The bench runs seeded random reads and writes with random select masks, data and wait settings from 0 to 5. Each access holds its strobe for two cycles past the expected acknowledge, so an early, late or repeated acknowledge can be told apart. The random select masks separate a shared enable from per-lane gating, and mixing reads with writes shows whether the bus write enable reaches `mem_we`. Directed cases cover a write enable with no strobe, a cycle dropped in the middle of a wait count and then restarted, and a strobe held high during reset.

// File: rtl/wb_sram_pkg.sv
package wb_sram_pkg;
  typedef struct packed {
    logic ce;
    logic we;
  } lane_ctl_t;

  function automatic int bus_width(input int banks, input int bank_dw);
    return banks * bank_dw;
  endfunction
endpackage

// File: rtl/wb_sram_lane.sv
module wb_sram_lane
  import wb_sram_pkg::*;
#(
  parameter int BANK_DW = 8
) (
  input  logic               active,
  input  logic               sel,
  input  logic               bus_we,
  input  logic [BANK_DW-1:0] bus_wdata,
  input  logic [BANK_DW-1:0] bank_rdata,
  output lane_ctl_t          ctl,
  output logic [BANK_DW-1:0] bank_wdata,
  output logic [BANK_DW-1:0] bus_rdata
);
  always_comb begin
    ctl.ce     = active & sel;
    ctl.we     = active & sel & bus_we;
    bank_wdata = bus_wdata;
    bus_rdata  = bank_rdata;
  end
endmodule

// File: rtl/wb_wait_timer.sv
module wb_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              ack
);
  logic [WAIT_W-1:0] cnt;
  logic              served;

  assign ack = !rst && active && !served && (cnt == wait_cfg);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt    <= '0;
      served <= 1'b0;
    end else if (ack) begin
      served <= 1'b1;
    end else if (cnt != wait_cfg) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wb_sram_banks.sv
module wb_sram_banks
  import wb_sram_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int BANK_AW = 10,
  parameter int BANK_DW = 8,
  parameter int WAIT_W  = 4,
  localparam int BUS_DW = BANKS * BANK_DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wb_cyc,
  input  logic               wb_stb,
  input  logic               wb_we,
  input  logic [BANK_AW-1:0] wb_adr,
  input  logic [BANKS-1:0]   wb_sel,
  input  logic [BUS_DW-1:0]  wb_dat_w,
  output logic [BUS_DW-1:0]  wb_dat_r,
  output logic               wb_ack,
  input  logic [WAIT_W-1:0]  wait_cfg,
  output logic [BANK_AW-1:0] mem_addr,
  output logic [BUS_DW-1:0]  mem_wdata,
  input  logic [BUS_DW-1:0]  mem_rdata,
  output logic [BANKS-1:0]   mem_ce,
  output logic [BANKS-1:0]   mem_we
);
  logic active;
  assign active   = wb_cyc & wb_stb;
  assign mem_addr = wb_adr;

  for (genvar k = 0; k < BANKS; k++) begin : g_lane
    lane_ctl_t ctl;
    wb_sram_lane #(.BANK_DW(BANK_DW)) u_lane (
      .active     (active),
      .sel        (wb_sel[k]),
      .bus_we     (wb_we),
      .bus_wdata  (wb_dat_w[k*BANK_DW +: BANK_DW]),
      .bank_rdata (mem_rdata[k*BANK_DW +: BANK_DW]),
      .ctl        (ctl),
      .bank_wdata (mem_wdata[k*BANK_DW +: BANK_DW]),
      .bus_rdata  (wb_dat_r[k*BANK_DW +: BANK_DW])
    );
    assign mem_ce[k] = ctl.ce;
    assign mem_we[k] = ctl.we;
  end

  wb_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .wait_cfg (wait_cfg),
    .ack      (wb_ack)
  );
endmodule

// File: rtl/wb_sram_banks_chk.sv
module wb_sram_banks_chk #(
  parameter int BANKS   = 4,
  parameter int BANK_AW = 10,
  parameter int WAIT_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wb_cyc,
  input logic               wb_stb,
  input logic               wb_we,
  input logic [BANK_AW-1:0] wb_adr,
  input logic [BANKS-1:0]   wb_sel,
  input logic               wb_ack,
  input logic [WAIT_W-1:0]  wait_cfg,
  input logic [BANK_AW-1:0] mem_addr,
  input logic [BANKS-1:0]   mem_ce,
  input logic [BANKS-1:0]   mem_we
);
  logic act;
  assign act = wb_cyc & wb_stb;

  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !act |-> (mem_ce == '0 && mem_we == '0));
  // R4
  ce_lane_chk: assert property (@(posedge clk) disable iff (rst)
    act |-> (mem_ce == wb_sel));
  // R5
  we_read_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_we |-> (mem_we == '0));
  // R2
  addr_share_chk: assert property (@(posedge clk) disable iff (rst)
    mem_addr == wb_adr);
  // R6
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !$past(act) && wait_cfg == '0) |-> wb_ack);
  // R7
  early_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !$past(act) && wait_cfg != '0) |-> !wb_ack);
  // R8
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_ack) && $past(act) && act) |-> !wb_ack);
  // R9
  ack_qual_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> act);
endmodule

bind wb_sram_banks wb_sram_banks_chk #(
  .BANKS(BANKS), .BANK_AW(BANK_AW), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_ack(wb_ack), .wait_cfg(wait_cfg),
  .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_we(mem_we)
);

// File: tb/wb_sram_banks_bench.sv
module wb_sram_banks_bench;
  localparam int BANKS = 4, BANK_AW = 10, BANK_DW = 8, WAIT_W = 4;
  localparam int BUS_DW = BANKS * BANK_DW;

  logic clk = 1'b0, rst = 1'b1;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [BANK_AW-1:0] wb_adr = '0;
  logic [BANKS-1:0]   wb_sel = '0;
  logic [BUS_DW-1:0]  wb_dat_w = '0, mem_rdata = '0;
  logic [WAIT_W-1:0]  wait_cfg = '0;
  logic [BUS_DW-1:0]  wb_dat_r, mem_wdata;
  logic               wb_ack;
  logic [BANK_AW-1:0] mem_addr;
  logic [BANKS-1:0]   mem_ce, mem_we;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wb_sram_banks #(.BANKS(BANKS), .BANK_AW(BANK_AW), .BANK_DW(BANK_DW), .WAIT_W(WAIT_W))
  u_wb_sram_banks (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .wait_cfg(wait_cfg), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ce(mem_ce), .mem_we(mem_we)
  );

  function automatic logic [BANKS-1:0] exp_ce(input logic c, input logic s, input logic [BANKS-1:0] sel);
    return (c && s) ? sel : '0;
  endfunction

  function automatic logic [BANKS-1:0] exp_we(input logic c, input logic s, input logic w,
                                              input logic [BANKS-1:0] sel);
    return (c && s && w) ? sel : '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ports(input logic exp_ack);
    #1;
    chk("R1 wdata", 64'(mem_wdata), 64'(wb_dat_w));
    chk("R1 rdata", 64'(wb_dat_r), 64'(mem_rdata));
    chk("R2 addr", 64'(mem_addr), 64'(wb_adr));
    chk("R3/R4 ce", 64'(mem_ce), 64'(exp_ce(wb_cyc, wb_stb, wb_sel)));
    chk("R5 we", 64'(mem_we), 64'(exp_we(wb_cyc, wb_stb, wb_we, wb_sel)));
    chk("R6/R7/R8 ack", 64'(wb_ack), 64'(exp_ack));
  endtask

  // strobe held for w+3 cycles; ack expected only in cycle w
  task automatic hold_strobe(input int w);
    for (int i = 0; i <= w + 2; i++) begin
      check_ports(i == w);
      @(negedge clk);
    end
  endtask

  task automatic access(input logic we, input logic [BANKS-1:0] sel, input int w);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_sel = sel;
    wb_adr = BANK_AW'($urandom); wb_dat_w = BUS_DW'($urandom);
    mem_rdata = BUS_DW'($urandom); wait_cfg = WAIT_W'(w);
    hold_strobe(w);
    wb_stb = 0;
    wb_cyc = 1'($urandom);
    check_ports(1'b0);       // R9 ack gone with strobe
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R10: strobe high during reset, zero wait
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wait_cfg = '0;
    #1 chk("R10 ack in reset", 64'(wb_ack), 64'd0);
    @(negedge clk);
    #1 chk("R10 ack in reset", 64'(wb_ack), 64'd0);
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R3: write enable without strobe
    wb_cyc = 1; wb_we = 1; wb_sel = '1;
    check_ports(1'b0);
    @(negedge clk);

    // R5: write to upper lanes only
    access(1'b1, 4'b1100, 0);
    access(1'b0, 4'b1111, 1);
    access(1'b1, 4'b0011, 3);

    // R9: cycle dropped in the middle of a count, then restarted from cycle 0
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_sel = 4'b0101; wait_cfg = 4'd3;
    check_ports(1'b0);
    @(negedge clk);
    check_ports(1'b0);
    @(negedge clk);
    wb_cyc = 0;
    check_ports(1'b0);
    @(negedge clk);
    wb_cyc = 1;
    hold_strobe(3);
    wb_stb = 0;
    check_ports(1'b0);
    @(negedge clk);

    // random mix
    for (int n = 0; n < 60; n++)
      access(1'($urandom), BANKS'($urandom), int'($urandom_range(0, 5)));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule